// File: doc/BRIEF.md
# Virtual Interrupt Flag Controller

This block resolves the four interrupt-flag instructions (clear, set, push flags, pop flags) issued by a task running in virtual-8086 mode. It receives one decoded instruction per cycle together with the current 16-bit flags word, the virtual interrupt flag (VIF), the virtual interrupt pending bit (VIP), the extension enable (VME) and, for a pop, the word read from the stack. It returns the updated flags word and VIF, the image to be written to the stack for a push, and a general-protection fault request.

The I/O privilege level field and VME together choose one of three handling modes. With IOPL at its maximum the instructions act on the real IF. With a lower IOPL and VME set they are redirected onto VIF, so the monitor is not entered for ordinary interrupt masking. With a lower IOPL and VME clear they trap. In the redirected mode, any attempt to turn VIF on while a deferred interrupt is pending (VIP=1) traps instead, so the monitor can deliver the interrupt first. VIP is only read; software owns it.

Results are registered: they appear one clock after the instruction is presented, with single-cycle strobes for completion, fault and push.

Top module: `vif_flag_ctrl`

## Requirements
- R1: After synchronous active-low reset, res_valid, gp_fault, push_valid, push_img, flags_out and vif_out are all zero.
- R2: instr_op encodes 0 = clear IF, 1 = set IF, 2 = push flags, 3 = pop flags; each cycle with instr_valid high yields res_valid high for exactly the following cycle, and push_valid is high only for a push that does not fault.
- R3: With IOPL (flags bits 13:12) equal to 3, clear and set change only flags bit 9 (IF) to 0 or 1, leave VIF unchanged and never fault, whatever VME is.
- R4: With IOPL equal to 3, a push outputs push_img equal to flags_in and leaves flags and VIF unchanged.
- R5: With IOPL equal to 3, a pop loads every flags bit from pop_word except bits 13:12, which keep their current value; VIF is unchanged.
- R6: With IOPL below 3 and VME clear, all four instructions fault: flags_out and vif_out equal the presented flags_in and vif_in, and push_valid stays low.
- R7: With IOPL below 3 and VME set, clear sets VIF to 0 and leaves the flags word (including IF) unchanged.
- R8: In that redirected mode, set makes VIF 1 when VIP is 0, and faults with flags and VIF unchanged when VIP is 1.
- R9: In the redirected mode, a push outputs flags_in with bit 9 replaced by VIF and bits 13:12 forced to 3; flags and VIF are unchanged.
- R10: In the redirected mode, a pop copies pop_word bit 9 into VIF, keeps the current IF and IOPL bits, and loads all other flags bits from pop_word.
- R11: In the redirected mode, a pop with pop_word bit 9 set faults when VIP is 1 (flags and VIF unchanged); a pop with bit 9 clear never faults, regardless of VIP.
- R12: In a cycle after one without instr_valid, res_valid, gp_fault and push_valid are low and flags_out and vif_out keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_op | input | 2 | Instruction code (0 clear, 1 set, 2 push, 3 pop) |
| flags_in | input | 16 | Current flags word (IF bit 9, IOPL bits 13:12) |
| vif_in | input | 1 | Current virtual interrupt flag |
| vip_in | input | 1 | Virtual interrupt pending bit (read only) |
| vme_en | input | 1 | Virtual interrupt extensions enable |
| pop_word | input | 16 | Word read from the stack for a pop |
| res_valid | output | 1 | Result of the previous cycle's instruction is present |
| gp_fault | output | 1 | General-protection fault request, one cycle |
| push_valid | output | 1 | push_img is to be written to the stack |
| push_img | output | 16 | Flags image for a push |
| flags_out | output | 16 | Updated flags word |
| vif_out | output | 1 | Updated virtual interrupt flag |

## Verification
On every cycle the assertions check that a fault leaves flags and VIF exactly as presented, that IOPL never changes, that VIF never turns on while VIP was set, that the redirected mode never touches IF, and that strobes only accompany a completed instruction. The exact per-mode results of each instruction, such as the forced IOPL and substituted IF in a redirected push image or the merging of a popped word, can only be shown by the bench's directed scenarios, which compare against hand-derived words.

// File: rtl/vifc_pkg.sv
// Package: shared types for the virtual interrupt flag controller.
// Assumes a 2-bit instruction code produced by an upstream decoder.
package vifc_pkg;

    // Interrupt-flag instruction codes.
    typedef enum logic [1:0] {
        OP_CLR  = 2'd0,
        OP_SET  = 2'd1,
        OP_PUSH = 2'd2,
        OP_POP  = 2'd3
    } flag_op_e;

    // Handling mode chosen from IOPL and the enable bit.
    typedef enum logic [1:0] {
        MODE_NATIVE  = 2'd0,
        MODE_VIRTUAL = 2'd1,
        MODE_TRAP    = 2'd2
    } ctl_mode_e;

endpackage

// File: rtl/vifc_mode_sel.sv
// Module: vifc_mode_sel
// Chooses how interrupt-flag instructions are handled: on the real IF
// when IOPL is at its maximum, on VIF when the extension is enabled and
// IOPL is lower, otherwise by trapping. Purely combinational.
module vifc_mode_sel
    import vifc_pkg::*;
#(
    parameter int IOPL_W = 2
) (
    input  logic [IOPL_W-1:0] iopl,
    input  logic              vme_en,
    output ctl_mode_e         mode
);
    localparam logic [IOPL_W-1:0] IOPL_MAX = {IOPL_W{1'b1}};

    // Map privilege level and enable onto a handling mode.
    always_comb begin
        if (iopl == IOPL_MAX)
            mode = MODE_NATIVE;
        else if (vme_en)
            mode = MODE_VIRTUAL;
        else
            mode = MODE_TRAP;
    end
endmodule

// File: rtl/vifc_flag_calc.sv
// Module: vifc_flag_calc
// Computes the next flags word, next VIF, push image and fault for one
// instruction in a given handling mode. Assumes the mode is valid for
// the current IOPL. A fault suppresses every state change.
module vifc_flag_calc
    import vifc_pkg::*;
#(
    parameter int FLAGS_W  = 16,
    parameter int IF_POS   = 9,
    parameter int IOPL_POS = 12,
    parameter int IOPL_W   = 2
) (
    input  flag_op_e           op,
    input  ctl_mode_e          mode,
    input  logic [FLAGS_W-1:0] flags_in,
    input  logic               vif_in,
    input  logic               vip_in,
    input  logic [FLAGS_W-1:0] pop_word,
    output logic [FLAGS_W-1:0] nxt_flags,
    output logic               nxt_vif,
    output logic [FLAGS_W-1:0] nxt_push,
    output logic               push_req,
    output logic               fault
);
    localparam logic [FLAGS_W-1:0] IOPL_MASK =
        FLAGS_W'(((1 << IOPL_W) - 1) << IOPL_POS);
    localparam logic [FLAGS_W-1:0] IF_MASK   = FLAGS_W'(1) << IF_POS;
    localparam logic [FLAGS_W-1:0] KEEP_MASK = IOPL_MASK | IF_MASK;

    logic [FLAGS_W-1:0] native_pop;
    logic [FLAGS_W-1:0] virt_pop;
    logic [FLAGS_W-1:0] virt_img;

    // Pop merges: native keeps IOPL; redirected keeps IOPL and IF.
    always_comb begin
        native_pop = (pop_word & ~IOPL_MASK) | (flags_in & IOPL_MASK);
        virt_pop   = (pop_word & ~KEEP_MASK) | (flags_in & KEEP_MASK);
    end

    // Redirected push image: IOPL reads as maximum, IF slot carries VIF.
    always_comb begin
        virt_img         = (flags_in & ~IOPL_MASK) | IOPL_MASK;
        virt_img[IF_POS] = vif_in;
    end

    // Select the result for the instruction and mode, then apply fault.
    always_comb begin
        nxt_flags = flags_in;
        nxt_vif   = vif_in;
        nxt_push  = '0;
        push_req  = 1'b0;
        fault     = 1'b0;
        case (mode)
            MODE_NATIVE: begin
                case (op)
                    OP_CLR:  nxt_flags[IF_POS] = 1'b0;
                    OP_SET:  nxt_flags[IF_POS] = 1'b1;
                    OP_PUSH: begin
                        push_req = 1'b1;
                        nxt_push = flags_in;
                    end
                    default: nxt_flags = native_pop;
                endcase
            end
            MODE_VIRTUAL: begin
                case (op)
                    OP_CLR:  nxt_vif = 1'b0;
                    OP_SET: begin
                        if (vip_in) fault = 1'b1;
                        else        nxt_vif = 1'b1;
                    end
                    OP_PUSH: begin
                        push_req = 1'b1;
                        nxt_push = virt_img;
                    end
                    default: begin
                        if (pop_word[IF_POS] && vip_in) begin
                            fault = 1'b1;
                        end else begin
                            nxt_flags = virt_pop;
                            nxt_vif   = pop_word[IF_POS];
                        end
                    end
                endcase
            end
            default: fault = 1'b1;
        endcase
        if (fault) begin
            nxt_flags = flags_in;
            nxt_vif   = vif_in;
            nxt_push  = '0;
            push_req  = 1'b0;
        end
    end
endmodule

// File: rtl/vif_flag_ctrl.sv
// Module: vif_flag_ctrl (top)
// Resolves interrupt-flag instructions of a virtual-8086 task against
// the real IF, the virtual VIF, or a general-protection trap, and
// registers the outcome one cycle after the instruction is presented.
// Assumes VIP is owned by software and is never written here.
module vif_flag_ctrl
    import vifc_pkg::*;
#(
    parameter int FLAGS_W  = 16,
    parameter int IF_POS   = 9,
    parameter int IOPL_POS = 12,
    parameter int IOPL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [1:0]         instr_op,
    input  logic [FLAGS_W-1:0] flags_in,
    input  logic               vif_in,
    input  logic               vip_in,
    input  logic               vme_en,
    input  logic [FLAGS_W-1:0] pop_word,
    output logic               res_valid,
    output logic               gp_fault,
    output logic               push_valid,
    output logic [FLAGS_W-1:0] push_img,
    output logic [FLAGS_W-1:0] flags_out,
    output logic               vif_out
);
    localparam int IOPL_HI = IOPL_POS + IOPL_W - 1;

    ctl_mode_e          mode;
    logic [FLAGS_W-1:0] c_flags;
    logic [FLAGS_W-1:0] c_push;
    logic               c_vif;
    logic               c_push_req;
    logic               c_fault;

    vifc_mode_sel #(.IOPL_W(IOPL_W)) u_mode (
        .iopl   (flags_in[IOPL_HI:IOPL_POS]),
        .vme_en (vme_en),
        .mode   (mode)
    );

    vifc_flag_calc #(
        .FLAGS_W (FLAGS_W),
        .IF_POS  (IF_POS),
        .IOPL_POS(IOPL_POS),
        .IOPL_W  (IOPL_W)
    ) u_calc (
        .op        (flag_op_e'(instr_op)),
        .mode      (mode),
        .flags_in  (flags_in),
        .vif_in    (vif_in),
        .vip_in    (vip_in),
        .pop_word  (pop_word),
        .nxt_flags (c_flags),
        .nxt_vif   (c_vif),
        .nxt_push  (c_push),
        .push_req  (c_push_req),
        .fault     (c_fault)
    );

    // Single-cycle strobes for completion, fault and push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            gp_fault   <= 1'b0;
            push_valid <= 1'b0;
        end else begin
            res_valid  <= instr_valid;
            gp_fault   <= instr_valid & c_fault;
            push_valid <= instr_valid & c_push_req;
        end
    end

    // Result data, loaded only when an instruction is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_out <= '0;
            vif_out   <= 1'b0;
            push_img  <= '0;
        end else if (instr_valid) begin
            flags_out <= c_flags;
            vif_out   <= c_vif;
            push_img  <= c_push;
        end
    end

    // R6
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> (flags_out == $past(flags_in)) && (vif_out == $past(vif_in)));

    // R12
    fault_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_fault || push_valid) |-> res_valid);

    // R2
    push_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !gp_fault);

    // R8
    vip_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && vif_out && !$past(vif_in)) |-> !$past(vip_in));

    // R5
    iopl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> flags_out[IOPL_HI:IOPL_POS] == $past(flags_in[IOPL_HI:IOPL_POS]));

    // R7
    virt_if_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode == MODE_VIRTUAL)) |->
            flags_out[IF_POS] == $past(flags_in[IF_POS]));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!gp_fault && !push_valid));
endmodule

// File: tb/sim_vif_flag_ctrl.sv
module sim_vif_flag_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [1:0]  instr_op = 2'd0;
    logic [15:0] flags_in = '0;
    logic        vif_in = 1'b0;
    logic        vip_in = 1'b0;
    logic        vme_en = 1'b0;
    logic [15:0] pop_word = '0;
    logic        res_valid, gp_fault, push_valid, vif_out;
    logic [15:0] push_img, flags_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vif_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .flags_in(flags_in), .vif_in(vif_in), .vip_in(vip_in), .vme_en(vme_en),
        .pop_word(pop_word), .res_valid(res_valid), .gp_fault(gp_fault),
        .push_valid(push_valid), .push_img(push_img), .flags_out(flags_out),
        .vif_out(vif_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one instruction at a falling edge; results are registered at
    // the next rising edge and sampled at the falling edge after it.
    task automatic issue(input logic [1:0] op, input logic [15:0] f, input logic vif,
                         input logic vip, input logic vme, input logic [15:0] pw);
        instr_valid = 1'b1; instr_op = op; flags_in = f; vif_in = vif;
        vip_in = vip; vme_en = vme; pop_word = pw;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic [15:0] ef, input logic ev,
                              input logic eg, input logic ep);
        chk(res_valid == 1'b1, req, 32'(res_valid), 32'd1);
        chk(flags_out == ef, req, 32'(flags_out), 32'(ef));
        chk(vif_out == ev, req, 32'(vif_out), 32'(ev));
        chk(gp_fault == eg, req, 32'(gp_fault), 32'(eg));
        chk(push_valid == ep, req, 32'(push_valid), 32'(ep));
    endtask

    task automatic t_reset();
        chk({res_valid, gp_fault, push_valid, vif_out} == 4'b0, "R1",
            32'({res_valid, gp_fault, push_valid, vif_out}), 32'd0);
        chk(flags_out == 16'h0 && push_img == 16'h0, "R1",
            {flags_out, push_img}, 32'd0);
    endtask

    task automatic t_native();
        issue(2'd0, 16'h3246, 1'b1, 1'b1, 1'b1, 16'h0);   // clear IF, IOPL=3
        expect_res("R3", 16'h3046, 1'b1, 1'b0, 1'b0);
        issue(2'd1, 16'h3046, 1'b0, 1'b1, 1'b0, 16'h0);   // set IF
        expect_res("R3", 16'h3246, 1'b0, 1'b0, 1'b0);
        issue(2'd2, 16'h3246, 1'b0, 1'b0, 1'b1, 16'h0);   // push
        expect_res("R4", 16'h3246, 1'b0, 1'b0, 1'b1);
        chk(push_img == 16'h3246, "R4", 32'(push_img), 32'h3246);
        issue(2'd3, 16'h3246, 1'b1, 1'b1, 1'b0, 16'h1ABC); // pop keeps IOPL
        expect_res("R5", 16'h3ABC, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_trap();
        for (int op = 0; op < 4; op++) begin
            issue(2'(op), 16'h1246, 1'b1, 1'b0, 1'b0, 16'h0A55);
            expect_res("R6", 16'h1246, 1'b1, 1'b1, 1'b0);
        end
    endtask

    task automatic t_virtual();
        issue(2'd0, 16'h0246, 1'b1, 1'b0, 1'b1, 16'h0);   // clear VIF
        expect_res("R7", 16'h0246, 1'b0, 1'b0, 1'b0);
        issue(2'd1, 16'h0246, 1'b0, 1'b0, 1'b1, 16'h0);   // set VIF, VIP=0
        expect_res("R8", 16'h0246, 1'b1, 1'b0, 1'b0);
        issue(2'd1, 16'h0246, 1'b0, 1'b1, 1'b1, 16'h0);   // set VIF, VIP=1
        expect_res("R8", 16'h0246, 1'b0, 1'b1, 1'b0);
        issue(2'd2, 16'h0246, 1'b0, 1'b0, 1'b1, 16'h0);   // push, VIF=0
        expect_res("R9", 16'h0246, 1'b0, 1'b0, 1'b1);
        chk(push_img == 16'h3046, "R9", 32'(push_img), 32'h3046);
        issue(2'd2, 16'h1046, 1'b1, 1'b0, 1'b1, 16'h0);   // push, VIF=1
        chk(push_img == 16'h3246, "R9", 32'(push_img), 32'h3246);
        issue(2'd3, 16'h1046, 1'b0, 1'b0, 1'b1, 16'h0A55); // pop IF=1, VIP=0
        expect_res("R10", 16'h1855, 1'b1, 1'b0, 1'b0);
        issue(2'd3, 16'h1046, 1'b1, 1'b1, 1'b1, 16'h0855); // pop IF=0, VIP=1
        expect_res("R11", 16'h1855, 1'b0, 1'b0, 1'b0);
        issue(2'd3, 16'h1046, 1'b0, 1'b1, 1'b1, 16'h0A55); // pop IF=1, VIP=1
        expect_res("R11", 16'h1046, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_idle();
        flags_in = 16'hFFFF; vif_in = 1'b1; pop_word = 16'hFFFF;
        @(negedge clk);
        chk({res_valid, gp_fault, push_valid} == 3'b0, "R2",
            32'({res_valid, gp_fault, push_valid}), 32'd0);
        chk(flags_out == 16'h1046 && vif_out == 1'b0, "R12",
            {15'd0, vif_out, flags_out}, 32'h1046);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_native();
        t_trap();
        t_virtual();
        t_idle();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule